// File: doc/BRIEF.md
# Stack Pointer and Frame Address Unit

This block keeps the two stack registers of a small 16-bit processor whose memory is addressed in words, so neighbouring words sit one address apart. It holds a 12-bit stack pointer and a 12-bit frame pointer. From them it forms the full 16-bit memory address for each stack access. Every address it emits has an all-ones upper nibble, so stack traffic always stays in the highest 4K words of the 64K-word space.

On every cycle the processor's control logic presents an operation code, a signed word offset and a load value. The unit responds in two ways. In the same cycle it drives the address of the access through `mem_addr`, which is combinational. On the next clock edge it updates the pointers. The stack grows toward lower addresses: a push or call writes one word below the current top, and a pop or return reads at the top. Frame operations copy SP into FP or FP into SP. The frame access operation forms FP plus an offset for reaching arguments and locals. This sum wraps within the 12-bit field and never leaves the stack region.

Top module: `stack_ptr_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sp` and `fp` become 12'h000. With op NOP after reset, `mem_addr` reads 16'hF000.
- R2: Op code 1 (push) drives `mem_addr` = {4'hF, sp-1} in the cycle it is presented. After the next edge, `sp` equals the old `sp` minus 1, modulo 4096. From `sp` = 000 the address is 16'hFFFF.
- R3: Op code 2 (pop) drives `mem_addr` = {4'hF, sp}. After the next edge, `sp` equals the old `sp` plus 1, modulo 4096.
- R4: Op code 3 (call) behaves as a push, and op code 4 (return) behaves as a pop, for both the address and the `sp` update.
- R5: Op code 5 (enter) copies `sp` into `fp` at the next edge and leaves `sp` unchanged.
- R6: Op code 6 (leave) copies `fp` into `sp` at the next edge and leaves `fp` unchanged.
- R7: Op code 7 (frame access) drives `mem_addr` = {4'hF, (fp + sign-extended `offset`) mod 4096}. It changes neither pointer.
- R8: Bits 15:12 of `mem_addr` are 4'hF in every cycle and for every op code.
- R9: Op code 8 loads `sp` from `load_val[11:0]`, and op code 9 loads `fp` from `load_val[11:0]`, each at the next edge. The other pointer keeps its value.
- R10: Op code 0 and op codes 10 to 15 leave both pointers unchanged and drive `mem_addr` = {4'hF, sp}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op | input | 4 | Operation code for this cycle |
| offset | input | 8 | Signed word offset for frame access |
| load_val | input | 16 | Value for pointer loads; the low 12 bits are used |
| mem_addr | output | 16 | Stack memory address for the current access |
| sp | output | 12 | Stack pointer |
| fp | output | 12 | Frame pointer |

## Verification
The assertions assume that `op` holds a defined level on every clock edge and stays at NOP while reset is asserted. The bench drives all inputs on the falling edge, keeps `op` at NOP during reset, and applies exactly one operation per cycle, so each pointer check refers to a single well-defined operation in the previous cycle. The stimulus also steps the pointers across the 000/FFF boundary in both directions and gives frame offsets whose sum wraps. This way the modular behaviour the properties rely on is actually exercised.

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int PTR_W  = 12,
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op,
  input  logic [OFF_W-1:0]  offset,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PTR_W-1:0]  sp,
  output logic [PTR_W-1:0]  fp
);
  localparam int HI_W = ADDR_W - PTR_W;

  localparam logic [3:0] OP_PUSH  = 4'd1;
  localparam logic [3:0] OP_POP   = 4'd2;
  localparam logic [3:0] OP_CALL  = 4'd3;
  localparam logic [3:0] OP_RET   = 4'd4;
  localparam logic [3:0] OP_ENTER = 4'd5;
  localparam logic [3:0] OP_LEAVE = 4'd6;
  localparam logic [3:0] OP_FRAME = 4'd7;
  localparam logic [3:0] OP_LDSP  = 4'd8;
  localparam logic [3:0] OP_LDFP  = 4'd9;

  logic [PTR_W-1:0] sp_dec, sp_inc, off_ext, frame_ptr, acc_ptr;

  assign sp_dec    = sp - 1'b1;
  assign sp_inc    = sp + 1'b1;
  assign off_ext   = {{(PTR_W-OFF_W){offset[OFF_W-1]}}, offset};
  assign frame_ptr = fp + off_ext;

  always_comb begin
    case (op)
      OP_PUSH, OP_CALL: acc_ptr = sp_dec;
      OP_FRAME:         acc_ptr = frame_ptr;
      default:          acc_ptr = sp;
    endcase
  end

  assign mem_addr = {{HI_W{1'b1}}, acc_ptr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
      fp <= '0;
    end else begin
      case (op)
        OP_PUSH, OP_CALL: sp <= sp_dec;
        OP_POP, OP_RET:   sp <= sp_inc;
        OP_ENTER:         fp <= sp;
        OP_LEAVE:         sp <= fp;
        OP_LDSP:          sp <= load_val[PTR_W-1:0];
        OP_LDFP:          fp <= load_val[PTR_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk #(
  parameter int PTR_W  = 12,
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op,
  input logic [OFF_W-1:0]  offset,
  input logic [ADDR_W-1:0] load_val,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [PTR_W-1:0]  sp,
  input logic [PTR_W-1:0]  fp
);
  localparam int HI_W = ADDR_W - PTR_W;

  AST_TOP_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[ADDR_W-1:PTR_W] == {HI_W{1'b1}}); // R8

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd1 || op == 4'd3) |=> sp == $past(sp) - 1'b1); // R2

  AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd2 || op == 4'd4) |=> sp == $past(sp) + 1'b1); // R3

  AST_ENTER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'd5 |=> (fp == $past(sp)) && (sp == $past(sp))); // R5

  AST_LEAVE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'd6 |=> (sp == $past(fp)) && (fp == $past(fp))); // R6

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'd7 |=> $stable(sp) && $stable(fp)); // R7

  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd0 || op >= 4'd10) |=> $stable(sp) && $stable(fp)); // R10

  AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'd1 |=> $past(mem_addr[PTR_W-1:0]) == sp); // R2
endmodule

bind stack_ptr_unit stack_ptr_unit_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_chk (.*);

// File: tb/test_stack_ptr_unit.sv
module test_stack_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [7:0]  offset = 8'd0;
  logic [15:0] load_val = 16'd0;
  logic [15:0] mem_addr;
  logic [11:0] sp, fp;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [11:0] m_sp = 12'h000;
  logic [11:0] m_fp = 12'h000;
  logic [11:0] q_sp[$];
  logic [11:0] q_fp[$];
  string       q_req[$];

  always #2 clk = ~clk;

  stack_ptr_unit i_stack_ptr_unit (
    .clk(clk), .rst_n(rst_n), .op(op), .offset(offset), .load_val(load_val),
    .mem_addr(mem_addr), .sp(sp), .fp(fp)
  );

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] c, input logic [7:0] off, input logic [15:0] lv,
                       input string req);
    logic [11:0] a;
    @(negedge clk);
    op = c; offset = off; load_val = lv;
    case (c)
      4'd1, 4'd3: a = m_sp - 12'd1;
      4'd7:       a = m_fp + {{4{off[7]}}, off};
      default:    a = m_sp;
    endcase
    #1;
    check16({req, " addr (R8)"}, mem_addr, {4'hF, a});
    case (c)
      4'd1, 4'd3: m_sp = m_sp - 12'd1;
      4'd2, 4'd4: m_sp = m_sp + 12'd1;
      4'd5:       m_fp = m_sp;
      4'd6:       m_sp = m_fp;
      4'd8:       m_sp = lv[11:0];
      4'd9:       m_fp = lv[11:0];
      default: ;
    endcase
    q_sp.push_back(m_sp);
    q_fp.push_back(m_fp);
    q_req.push_back(req);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q_sp.size() > 0) begin
        logic [11:0] esp, efp;
        string r;
        esp = q_sp.pop_front();
        efp = q_fp.pop_front();
        r   = q_req.pop_front();
        check16({r, " sp"}, {4'h0, sp}, {4'h0, esp});
        check16({r, " fp"}, {4'h0, fp}, {4'h0, efp});
      end
    end
  end

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check16("R1 sp", {4'h0, sp}, 16'h0000);
    check16("R1 fp", {4'h0, fp}, 16'h0000);
    check16("R1 addr", mem_addr, 16'hF000);

    do_op(4'd1, 8'd0, 16'd0, "R2 push");
    do_op(4'd1, 8'd0, 16'd0, "R2 push");
    do_op(4'd1, 8'd0, 16'd0, "R2 push");
    do_op(4'd5, 8'd0, 16'd0, "R5 enter");
    do_op(4'd1, 8'd0, 16'd0, "R2 push");
    do_op(4'd1, 8'd0, 16'd0, "R2 push");
    do_op(4'd7, 8'h01, 16'd0, "R7 frame +1");
    do_op(4'd7, 8'h03, 16'd0, "R7 frame +3");
    do_op(4'd7, 8'hFE, 16'd0, "R7 frame -2");
    do_op(4'd3, 8'd0, 16'd0, "R4 call");
    do_op(4'd4, 8'd0, 16'd0, "R4 ret");
    do_op(4'd6, 8'd0, 16'd0, "R6 leave");
    do_op(4'd2, 8'd0, 16'd0, "R3 pop");
    do_op(4'd2, 8'd0, 16'd0, "R3 pop");
    do_op(4'd2, 8'd0, 16'd0, "R3 pop");
    do_op(4'd2, 8'd0, 16'd0, "R3 pop wrap");
    do_op(4'd8, 8'd0, 16'h1234, "R9 load sp");
    do_op(4'd9, 8'd0, 16'hABCD, "R9 load fp");
    do_op(4'd6, 8'd0, 16'd0, "R6 leave loaded");
    do_op(4'd9, 8'd0, 16'h0FFE, "R9 load fp edge");
    do_op(4'd7, 8'h05, 16'd0, "R7 frame wrap up");
    do_op(4'd9, 8'd0, 16'h0002, "R9 load fp low");
    do_op(4'd7, 8'h80, 16'd0, "R7 frame wrap down");
    do_op(4'd0, 8'h55, 16'hFFFF, "R10 nop");
    do_op(4'd12, 8'h11, 16'h0777, "R10 code 12");
    do_op(4'd15, 8'h22, 16'h0888, "R10 code 15");
    do_op(4'd4, 8'd0, 16'd0, "R4 ret");
    do_op(4'd0, 8'd0, 16'd0, "R10 final");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule